// File: doc/BRIEF.md
# Multiplexer Carry-Chain Signed Adder

This block adds two k-bit two's-complement operands and a carry input in a single combinational pass. The carry path is built one bit at a time, the way a dedicated FPGA carry chain works. Each stage forms a propagate bit as the XOR of its two operand bits. That bit steers a 2:1 multiplexer that picks the stage's carry output.

When the propagate bit is clear, the two operand bits are equal. The multiplexer then outputs the second operand's bit, which serves as both generate and kill. When the propagate bit is set, the incoming carry passes straight through. No AND-OR carry equations are used anywhere on the carry path.

The sum bit of each stage is the propagate bit XOR its incoming carry. The signed overflow flag is the XOR of the carry out of the top stage and the carry into it. The carry-out port is the carry leaving the top stage. Delay grows linearly with the width because the carry ripples through every stage. Any registers around the adder belong to the surrounding logic.

Top module: `mux_chain_adder`

## Requirements
- R1: In any bit where the two operand bits differ, the carry leaving that bit equals the carry entering it. With opB equal to the bitwise inverse of opA, carryOut equals carryIn, and sumOut is all ones when carryIn is 0 and all zeros when carryIn is 1.
- R2: In any bit where the two operand bits are equal, the carry leaving that bit equals the opB bit, whatever the incoming carry. With opA equal to opB, the carry into bit i is opB[i-1], the carry into bit 0 is carryIn, and carryOut is opB[WIDTH-1].
- R3: Each sum bit i equals opA[i] XOR opB[i] XOR the carry into bit i.
- R4: For all inputs, {carryOut, sumOut} equals the unsigned value opA + opB + carryIn.
- R5: overflow equals the carry out of bit WIDTH-1 XOR the carry into bit WIDTH-1. It is 1 exactly when the two operands have the same sign bit and sumOut[WIDTH-1] differs from it, and it is 0 when the operand sign bits differ.
- R6: carryOut is the carry leaving bit WIDTH-1, so a carry entering bit 0 can ripple through all WIDTH stages. With opA all ones, opB zero and carryIn 1, sumOut is zero and carryOut is 1.
- R7: WIDTH must be at least 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand, two's complement |
| opB | input | WIDTH | Second operand; each bit also serves as that stage's generate input |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | WIDTH | Sum bits |
| carryOut | output | 1 | Carry leaving the most significant stage |
| overflow | output | 1 | Signed overflow flag |

## Verification
Whenever an input changes, the assertions check four things:

- Each stage's multiplexer passes the incoming carry when the operand bits differ and outputs the opB bit when they agree.
- Each stage's sum bit matches its inputs.
- The carry-derived overflow agrees with the sign-bit rule.
- The whole chain's result equals the arithmetic sum.

Only the bench scenarios show that these hold for every operand pair at a small width. They also show the extreme chains: a carry that rides all the way from bit 0 to carryOut, and all-equal operands whose carries never travel. Finally, the bench confirms that overflow is set exactly for signed results outside the representable range.

// File: rtl/adder_pkg.sv
package adder_pkg;
  // Per-stage steering pair: propagate selects, generate is the fallback.
  typedef struct packed {
    logic prop;
    logic gen;
  } pgPair_t;

  localparam int unsigned MIN_WIDTH = 2;
endpackage

// File: rtl/carry_stage.sv
module carry_stage
  import adder_pkg::*;
(
  input  logic xBit,
  input  logic yBit,
  input  logic carryIn,
  output logic sumBit,
  output logic carryOut
);
  pgPair_t pg;

  assign pg.prop  = xBit ^ yBit;
  assign pg.gen   = yBit;
  // 2:1 carry multiplexer steered by propagate.
  assign carryOut = pg.prop ? carryIn : pg.gen;
  assign sumBit   = pg.prop ^ carryIn;

  always_comb begin
    // R1
    if (xBit != yBit) begin
      carry_pass_chk: assert (carryOut == carryIn)
        else $error("carry not passed through differing stage");
    end
    // R2
    if (xBit == yBit) begin
      carry_gen_kill_chk: assert (carryOut == xBit)
        else $error("carry not set by equal operand bits");
    end
    // R3
    sum_bit_chk: assert (sumBit == (carryIn ? (xBit == yBit) : (xBit != yBit)))
      else $error("sum bit mismatch");
  end
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic [WIDTH:0]   carryVec
);
  localparam int unsigned SUM_W = WIDTH + 1;

  assign carryVec[0] = carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    carry_stage stage_i (
      .xBit     (opA[i]),
      .yBit     (opB[i]),
      .carryIn  (carryVec[i]),
      .sumBit   (sumOut[i]),
      .carryOut (carryVec[i+1])
    );
  end

  always_comb begin
    // R4
    add_value_chk: assert ({carryVec[WIDTH], sumOut} ==
                           (SUM_W'(opA) + SUM_W'(opB) + SUM_W'(carryIn)))
      else $error("chain result differs from arithmetic sum");
  end
endmodule

// File: rtl/overflow_unit.sv
module overflow_unit (
  input  logic carryTop,
  input  logic carryMsbIn,
  input  logic signA,
  input  logic signB,
  input  logic signSum,
  output logic overflow
);
  assign overflow = carryTop ^ carryMsbIn;

  always_comb begin
    // R5
    ovf_sign_rule_chk: assert (overflow ==
        ((signA & signB & ~signSum) | (~signA & ~signB & signSum)))
      else $error("overflow disagrees with sign rule");
  end
endmodule

// File: rtl/mux_chain_adder.sv
module mux_chain_adder #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut,
  output logic             overflow
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH:0] carryVec;

  // R7
  initial begin
    width_min_chk: assert (WIDTH >= adder_pkg::MIN_WIDTH)
      else $error("WIDTH below minimum");
  end

  ripple_chain #(.WIDTH(WIDTH)) chain_i (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .sumOut   (sumOut),
    .carryVec (carryVec)
  );

  overflow_unit ovf_i (
    .carryTop   (carryVec[WIDTH]),
    .carryMsbIn (carryVec[MSB]),
    .signA      (opA[MSB]),
    .signB      (opB[MSB]),
    .signSum    (sumOut[MSB]),
    .overflow   (overflow)
  );

  assign carryOut = carryVec[WIDTH];

  always_comb begin
    // R6
    if ((opA == '1) && (opB == '0)) begin
      carry_out_chk: assert ((carryOut == carryIn) && (sumOut == {WIDTH{~carryIn}}))
        else $error("full-length ripple wrong");
    end
  end
endmodule

// File: tb/mux_chain_adder_tb.sv
module mux_chain_adder_tb_top;
  localparam int W = 6;
  localparam int CLK_PERIOD = 10;
  localparam int MAXV = 1 << W;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] opA = '0, opB = '0;
  logic carryIn = 1'b0;
  logic [W-1:0] sumOut;
  logic carryOut, overflow;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_chain_adder #(.WIDTH(W)) dut_i (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sumOut(sumOut), .carryOut(carryOut), .overflow(overflow)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (a=%0d b=%0d c=%0d)",
               req, act, exp, opA, opB, carryIn);
    end
  endtask

  task automatic drive(input int a, input int b, input int c);
    @(posedge clk);
    opA = W'(a); opB = W'(b); carryIn = c[0];
    @(negedge clk);
  endtask

  // Full arithmetic check of one vector (R3, R4, R5, R6)
  task automatic applyAndCheck(input int a, input int b, input int c);
    int full, lowMask, cMsbIn, expCout, expOvf, sa, sb, ssum;
    drive(a, b, c);
    full    = a + b + c;
    lowMask = (1 << (W-1)) - 1;
    cMsbIn  = (((a & lowMask) + (b & lowMask) + c) >> (W-1)) & 1;
    expCout = (full >> W) & 1;
    expOvf  = expCout ^ cMsbIn;
    sa = (a >= MAXV/2) ? a - MAXV : a;
    sb = (b >= MAXV/2) ? b - MAXV : b;
    ssum = sa + sb + c;
    check("R4 sum", int'(sumOut), full & (MAXV-1));
    check("R6 carryOut", int'(carryOut), expCout);
    check("R5 overflow", int'(overflow), expOvf);
    check("R5 signed range", int'(overflow),
          ((ssum < -(MAXV/2)) || (ssum >= MAXV/2)) ? 1 : 0);
  endtask

  initial begin : watchdog
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Idle state with zero inputs
    check("R4 idle sum", int'(sumOut), 0);
    check("R6 idle carryOut", int'(carryOut), 0);
    check("R5 idle overflow", int'(overflow), 0);

    // R1: all stages propagate
    for (int c = 0; c < 2; c++) begin
      drive(6'b101100, 6'b010011, c);
      check("R1 cout passes cin", int'(carryOut), c);
      check("R1 sum", int'(sumOut), c ? 0 : MAXV-1);
      check("R5 R1 mixed signs no ovf", int'(overflow), 0);
    end

    // R2: all stages generate or kill
    for (int c = 0; c < 2; c++) begin
      drive(6'b101101, 6'b101101, c);
      check("R2 cout = opB msb", int'(carryOut), 1);
      check("R2 R3 sum", int'(sumOut), ((6'b101101 << 1) | c) & (MAXV-1));
      drive(6'b010010, 6'b010010, c);
      check("R2 cout = opB msb", int'(carryOut), 0);
      check("R2 R3 sum", int'(sumOut), ((6'b010010 << 1) | c) & (MAXV-1));
    end

    // R6: carry ripples through all stages
    drive(MAXV-1, 0, 1);
    check("R6 full ripple sum", int'(sumOut), 0);
    check("R6 full ripple cout", int'(carryOut), 1);

    // R5 corner: most positive plus one, most negative plus minus one
    applyAndCheck(MAXV/2 - 1, 1, 0);
    check("R5 pos+pos ovf", int'(overflow), 1);
    applyAndCheck(MAXV/2, MAXV-1, 0);
    check("R5 neg+neg ovf", int'(overflow), 1);

    // R3 R4 R5 R6: exhaustive sweep
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < MAXV; a++)
        for (int b = 0; b < MAXV; b++)
          applyAndCheck(a, b, c);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule